// File: doc/BRIEF.md
# Trap-Return State Unit

This unit carries out the two trap-return operations of a privileged core: the machine-level return and the supervisor-level return. A request comes with the current privilege level, the current virtualization flag, the machine status word, the hypervisor status word, both saved return addresses and the configuration flags. Before it updates anything, the unit decides whether the return is allowed. It runs a fixed sequence of refusal checks. If one of them fails, it reports the exception code of the first check that failed and passes all state through unchanged. If none fail, it produces the rewritten status words, the privilege and virtualization mode being returned to, and the return address. When the return re-enters virtualized mode, it raises a one-cycle strobe that tells the register file to exchange its shadow registers.

The unit has a single register stage. A request sampled on one rising edge has its result on the outputs after that edge, and the result stays there until the next request. The status word layout belongs to this project. Machine status: bit 0 supervisor interrupt enable, bit 1 machine interrupt enable, bit 2 supervisor previous enable, bit 3 machine previous enable, bit 4 supervisor previous privilege, bits 6:5 machine previous privilege, bit 7 machine previous virtualization, bit 8 trap-supervisor-return, bits 11:9 spare. Hypervisor status: bit 0 supervisor previous virtualization, bit 1 virtual trap-supervisor-return, bits 3:2 spare. Spare bits are passed through as they are. Privilege encoding: user=0, supervisor=1, machine=3.

Top module: `xret_unit`

## Requirements
- R1: `done` is high for exactly the cycle after each cycle in which `req_valid` is sampled high. After reset, `done`, `refused` and `swap_regs` are 0, `priv_out` is 3 (machine), `virt_out` is 0, and `pc_out` and `excp_code` are 0.
- R2: A machine return requested below machine privilege, or a supervisor return requested from user privilege, is refused with code 2 (illegal instruction).
- R3: When `cfg_has_c` is 0 and either of bits 1:0 of the selected return address is set, the return is refused with code 0 (misaligned target).
- R4: A supervisor return is refused with code 2 when machine-status bit 8 is set and the current privilege is not machine.
- R5: A supervisor return is refused with code 22 (virtual instruction) when `cfg_has_h` and `cur_virt` are both 1 and hypervisor-status bit 1 is set.
- R6: A machine return is refused with code 2 when `cfg_has_pmp` is 1, `pmp_rules` is 0, and machine-status bits 6:5 are not 3.
- R7: The checks are ranked privilege, then alignment, then machine-status bit 8, then hypervisor-status bit 1, then the protection check. Only the code of the highest-ranked failing check is reported.
- R8: On a refusal, `refused` pulses with `done`. `mstat_out`, `hstat_out`, `priv_out` and `virt_out` then equal the inputs of the request, and `swap_regs` stays 0.
- R9: An accepted machine return sets bit 1 to the old bit 3, sets bit 3 to 1, clears bits 6:5 and bit 7, and sets `priv_out` to the old bits 6:5. `virt_out` becomes the old bit 7 when `cfg_has_h` is 1 and otherwise stays at `cur_virt`.
- R10: An accepted supervisor return with `cfg_has_h`=1 and `cur_virt`=0 sets `virt_out` to hypervisor-status bit 0 and then clears that bit.
- R11: Every accepted supervisor return sets bit 0 to the old bit 2, sets bit 2 to 1, clears bit 4, and sets `priv_out` to the old bit 4 (0 user, 1 supervisor). Outside the case in R10, virtualization and the hypervisor word are left unchanged.
- R12: `swap_regs` pulses with `done` only when an accepted return restores a virtualization bit of 1 (R9 with `cfg_has_h`, or R10). It is 0 in all other cycles.
- R13: `pc_out` is `mepc_in` for a machine return and `sepc_in` for a supervisor return, whether or not the return is refused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Return request this cycle |
| req_is_mret | input | 1 | 1 = machine return, 0 = supervisor return |
| cur_priv | input | 2 | Current privilege level |
| cur_virt | input | 1 | Current virtualization flag |
| mstat_in | input | 12 | Machine status word |
| hstat_in | input | 4 | Hypervisor status word |
| mepc_in | input | XLEN | Saved machine return address |
| sepc_in | input | XLEN | Saved supervisor return address |
| cfg_has_h | input | 1 | Hypervisor support present |
| cfg_has_c | input | 1 | Compressed instructions present |
| cfg_has_pmp | input | 1 | Memory protection implemented |
| pmp_rules | input | PMP_W | Number of configured protection rules |
| done | output | 1 | Result valid pulse |
| refused | output | 1 | Return was refused |
| excp_code | output | 5 | Exception code of the refusal |
| mstat_out | output | 12 | Updated machine status word |
| hstat_out | output | 4 | Updated hypervisor status word |
| priv_out | output | 2 | Privilege after return |
| virt_out | output | 1 | Virtualization after return |
| pc_out | output | XLEN | Return address |
| swap_regs | output | 1 | Shadow-register exchange strobe |

## Verification
The hardest cases to reach are requests in which several refusal conditions are true at the same time. Only the ranking decides which code is reported, and a reordered check tree still passes every single-fault test. The vector table therefore holds requests that combine a privilege fault with misalignment, misalignment with an empty protection table, misalignment with the trap bit, and the trap bit with the virtual trap bit. A second hard case is the supervisor return made while already virtualized: the saved virtualization bit is set but must not be restored, and no swap may be requested. A table entry reaches it by driving `cur_virt`=1 with hypervisor-status bit 0 set.

// File: rtl/xret_pkg.sv
// Package: shared encodings and status-word bit positions for the
// trap-return unit. Assumes the compact status layouts described in the brief.
package xret_pkg;
    localparam int EXC_W = 5;
    localparam int MS_W  = 12;
    localparam int HS_W  = 4;

    localparam logic [1:0] PRIV_U = 2'd0;
    localparam logic [1:0] PRIV_S = 2'd1;
    localparam logic [1:0] PRIV_M = 2'd3;

    localparam logic [EXC_W-1:0] EXC_MISALIGN = 5'd0;
    localparam logic [EXC_W-1:0] EXC_ILLEGAL  = 5'd2;
    localparam logic [EXC_W-1:0] EXC_VIRT     = 5'd22;

    // machine status bit positions
    localparam int MS_SIE  = 0;
    localparam int MS_MIE  = 1;
    localparam int MS_SPIE = 2;
    localparam int MS_MPIE = 3;
    localparam int MS_SPP  = 4;
    localparam int MS_MPP  = 5;   // two bits, 6:5
    localparam int MS_MPV  = 7;
    localparam int MS_TSR  = 8;

    // hypervisor status bit positions
    localparam int HS_SPV  = 0;
    localparam int HS_VTSR = 1;

    // refusal checks, listed from highest to lowest rank
    typedef enum logic [2:0] {
        CHK_PRIV  = 3'd0,
        CHK_ALIGN = 3'd1,
        CHK_TSR   = 3'd2,
        CHK_VTSR  = 3'd3,
        CHK_PMP   = 3'd4
    } chk_e;
    localparam int NCHK = 5;
endpackage

// File: rtl/xret_checks.sv
// Module: xret_checks
// Evaluates every refusal condition of a trap return at once and picks the
// highest-ranked failing one. Purely combinational. Assumes the caller passes
// the low bits of the return address it has already selected.
module xret_checks
    import xret_pkg::*;
#(
    parameter int PMP_W = 4
) (
    input  logic             is_mret,
    input  logic [1:0]       cur_priv,
    input  logic             cur_virt,
    input  logic [MS_W-1:0]  mstat,
    input  logic [HS_W-1:0]  hstat,
    input  logic [1:0]       pc_lo,
    input  logic             has_h,
    input  logic             has_c,
    input  logic             has_pmp,
    input  logic [PMP_W-1:0] pmp_rules,
    output logic             fail,
    output logic [EXC_W-1:0] code
);
    logic [NCHK-1:0] hit;

    // code reported for each ranked check
    function automatic logic [EXC_W-1:0] code_of(input int idx);
        case (idx)
            int'(CHK_ALIGN): code_of = EXC_MISALIGN;
            int'(CHK_VTSR):  code_of = EXC_VIRT;
            default:         code_of = EXC_ILLEGAL;
        endcase
    endfunction

    // raw refusal conditions
    always_comb begin
        hit = '0;
        hit[CHK_PRIV]  = is_mret ? (cur_priv != PRIV_M) : (cur_priv < PRIV_S);
        hit[CHK_ALIGN] = !has_c && (|pc_lo);
        hit[CHK_TSR]   = !is_mret && mstat[MS_TSR] && (cur_priv != PRIV_M);
        hit[CHK_VTSR]  = !is_mret && has_h && cur_virt && hstat[HS_VTSR];
        hit[CHK_PMP]   = is_mret && has_pmp && (pmp_rules == '0) &&
                         (mstat[MS_MPP +: 2] != PRIV_M);
    end

    // priority pick: lowest index wins because it is assigned last
    always_comb begin
        fail = 1'b0;
        code = '0;
        for (int i = NCHK - 1; i >= 0; i--) begin
            if (hit[i]) begin
                fail = 1'b1;
                code = code_of(i);
            end
        end
    end
endmodule

// File: rtl/xret_update.sv
// Module: xret_update
// Computes the status words, privilege and virtualization mode that follow
// an accepted trap return, plus the shadow-swap request. Combinational.
// Assumes the caller discards these values when the return is refused.
module xret_update
    import xret_pkg::*;
(
    input  logic            is_mret,
    input  logic            cur_virt,
    input  logic [MS_W-1:0] mstat,
    input  logic [HS_W-1:0] hstat,
    input  logic            has_h,
    output logic [MS_W-1:0] mstat_nx,
    output logic [HS_W-1:0] hstat_nx,
    output logic [1:0]      priv_nx,
    output logic            virt_nx,
    output logic            swap_nx
);
    // next-state rewrite for both return kinds
    always_comb begin
        mstat_nx = mstat;
        hstat_nx = hstat;
        virt_nx  = cur_virt;
        swap_nx  = 1'b0;
        if (is_mret) begin
            mstat_nx[MS_MIE]       = mstat[MS_MPIE];
            mstat_nx[MS_MPIE]      = 1'b1;
            mstat_nx[MS_MPP +: 2]  = PRIV_U;
            mstat_nx[MS_MPV]       = 1'b0;
            priv_nx                = mstat[MS_MPP +: 2];
            if (has_h) begin
                virt_nx = mstat[MS_MPV];
                swap_nx = mstat[MS_MPV];
            end
        end else begin
            mstat_nx[MS_SIE]  = mstat[MS_SPIE];
            mstat_nx[MS_SPIE] = 1'b1;
            mstat_nx[MS_SPP]  = 1'b0;
            priv_nx           = {1'b0, mstat[MS_SPP]};
            if (has_h && !cur_virt) begin
                virt_nx          = hstat[HS_SPV];
                swap_nx          = hstat[HS_SPV];
                hstat_nx[HS_SPV] = 1'b0;
            end
        end
    end
endmodule

// File: rtl/xret_unit.sv
// Module: xret_unit (top)
// Single-stage trap-return unit. Checks a request, then either commits the
// rewritten state or reports a refusal with unchanged state. Outputs are
// registered and hold until the next request. Synchronous active-low reset.
module xret_unit
    import xret_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int PMP_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_is_mret,
    input  logic [1:0]       cur_priv,
    input  logic             cur_virt,
    input  logic [11:0]      mstat_in,
    input  logic [3:0]       hstat_in,
    input  logic [XLEN-1:0]  mepc_in,
    input  logic [XLEN-1:0]  sepc_in,
    input  logic             cfg_has_h,
    input  logic             cfg_has_c,
    input  logic             cfg_has_pmp,
    input  logic [PMP_W-1:0] pmp_rules,
    output logic             done,
    output logic             refused,
    output logic [4:0]       excp_code,
    output logic [11:0]      mstat_out,
    output logic [3:0]       hstat_out,
    output logic [1:0]       priv_out,
    output logic             virt_out,
    output logic [XLEN-1:0]  pc_out,
    output logic             swap_regs
);
    logic [XLEN-1:0]  pc_sel;
    logic             chk_fail;
    logic [EXC_W-1:0] chk_code;
    logic [MS_W-1:0]  ms_nx;
    logic [HS_W-1:0]  hs_nx;
    logic [1:0]       pv_nx;
    logic             vt_nx;
    logic             sw_nx;

    // return address chosen by the request kind
    assign pc_sel = req_is_mret ? mepc_in : sepc_in;

    xret_checks #(.PMP_W(PMP_W)) i_checks (
        .is_mret   (req_is_mret),
        .cur_priv  (cur_priv),
        .cur_virt  (cur_virt),
        .mstat     (mstat_in),
        .hstat     (hstat_in),
        .pc_lo     (pc_sel[1:0]),
        .has_h     (cfg_has_h),
        .has_c     (cfg_has_c),
        .has_pmp   (cfg_has_pmp),
        .pmp_rules (pmp_rules),
        .fail      (chk_fail),
        .code      (chk_code)
    );

    xret_update i_update (
        .is_mret  (req_is_mret),
        .cur_virt (cur_virt),
        .mstat    (mstat_in),
        .hstat    (hstat_in),
        .has_h    (cfg_has_h),
        .mstat_nx (ms_nx),
        .hstat_nx (hs_nx),
        .priv_nx  (pv_nx),
        .virt_nx  (vt_nx),
        .swap_nx  (sw_nx)
    );

    // result register: commit or pass-through on each request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done      <= 1'b0;
            refused   <= 1'b0;
            swap_regs <= 1'b0;
            excp_code <= '0;
            mstat_out <= '0;
            hstat_out <= '0;
            priv_out  <= PRIV_M;
            virt_out  <= 1'b0;
            pc_out    <= '0;
        end else begin
            done      <= req_valid;
            refused   <= req_valid && chk_fail;
            swap_regs <= req_valid && !chk_fail && sw_nx;
            if (req_valid) begin
                excp_code <= chk_fail ? chk_code : '0;
                pc_out    <= pc_sel;
                if (chk_fail) begin
                    mstat_out <= mstat_in;
                    hstat_out <= hstat_in;
                    priv_out  <= cur_priv;
                    virt_out  <= cur_virt;
                end else begin
                    mstat_out <= ms_nx;
                    hstat_out <= hs_nx;
                    priv_out  <= pv_nx;
                    virt_out  <= vt_nx;
                end
            end
        end
    end

    AST_DONE_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> done); // R1
    AST_PRIV_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_is_mret && cur_priv != PRIV_M) |=> (refused && excp_code == EXC_ILLEGAL)); // R2
    AST_MISALIGN_NEEDS_NO_C: assert property (@(posedge clk) disable iff (!rst_n)
        (done && refused && excp_code == EXC_MISALIGN) |-> !$past(cfg_has_c)); // R3
    AST_REFUSE_HOLDS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && chk_fail) |=> (mstat_out == $past(mstat_in) && priv_out == $past(cur_priv) && !swap_regs)); // R8
    AST_MRET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !refused && $past(req_is_mret)) |-> (mstat_out[MS_MPP +: 2] == PRIV_U && mstat_out[MS_MPIE] && !mstat_out[MS_MPV])); // R9
    AST_SWAP_ONLY_INTO_VIRT: assert property (@(posedge clk) disable iff (!rst_n)
        swap_regs |-> (virt_out && done && !refused)); // R12
endmodule

// File: tb/test_xret_unit.sv
`timescale 1ns/1ps
module test_xret_unit;
    localparam int XLEN  = 32;
    localparam int PMP_W = 4;
    localparam logic [XLEN-1:0] MEPC_BASE = 32'h8000_0100;
    localparam logic [XLEN-1:0] SEPC_BASE = 32'h4000_0200;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             req_valid, req_is_mret, cur_virt;
    logic [1:0]       cur_priv;
    logic [11:0]      mstat_in;
    logic [3:0]       hstat_in;
    logic [XLEN-1:0]  mepc_in, sepc_in;
    logic             cfg_has_h, cfg_has_c, cfg_has_pmp;
    logic [PMP_W-1:0] pmp_rules;
    logic             done, refused, virt_out, swap_regs;
    logic [4:0]       excp_code;
    logic [11:0]      mstat_out;
    logic [3:0]       hstat_out;
    logic [1:0]       priv_out;
    logic [XLEN-1:0]  pc_out;

    int n_cmp = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    xret_unit #(.XLEN(XLEN), .PMP_W(PMP_W)) i_xret_unit (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_is_mret(req_is_mret),
        .cur_priv(cur_priv), .cur_virt(cur_virt), .mstat_in(mstat_in), .hstat_in(hstat_in),
        .mepc_in(mepc_in), .sepc_in(sepc_in), .cfg_has_h(cfg_has_h), .cfg_has_c(cfg_has_c),
        .cfg_has_pmp(cfg_has_pmp), .pmp_rules(pmp_rules), .done(done), .refused(refused),
        .excp_code(excp_code), .mstat_out(mstat_out), .hstat_out(hstat_out),
        .priv_out(priv_out), .virt_out(virt_out), .pc_out(pc_out), .swap_regs(swap_regs)
    );

    typedef struct packed {
        logic        mret;
        logic [1:0]  priv;
        logic        virt;
        logic [11:0] ms;
        logic [3:0]  hs;
        logic        h;
        logic        c;
        logic        pmp;
        logic [3:0]  rules;
        logic [1:0]  pclo;
        logic        e_ref;
        logic [4:0]  e_code;
        logic [11:0] e_ms;
        logic [3:0]  e_hs;
        logic [1:0]  e_priv;
        logic        e_virt;
        logic        e_swap;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t VECS [NV] = '{
        '{1'b1,2'd3,1'b0,12'h228,4'h0,1'b1,1'b1,1'b1,4'd4,2'd0, 1'b0,5'd0, 12'h20A,4'h0,2'd1,1'b0,1'b0},
        '{1'b1,2'd3,1'b0,12'h0A2,4'h0,1'b1,1'b1,1'b1,4'd4,2'd0, 1'b0,5'd0, 12'h008,4'h0,2'd1,1'b1,1'b1},
        '{1'b1,2'd3,1'b0,12'h0A2,4'h0,1'b0,1'b1,1'b1,4'd4,2'd0, 1'b0,5'd0, 12'h008,4'h0,2'd1,1'b0,1'b0},
        '{1'b1,2'd1,1'b0,12'h228,4'h0,1'b1,1'b1,1'b1,4'd4,2'd0, 1'b1,5'd2, 12'h228,4'h0,2'd1,1'b0,1'b0},
        '{1'b1,2'd3,1'b0,12'h228,4'h0,1'b1,1'b0,1'b1,4'd4,2'd2, 1'b1,5'd0, 12'h228,4'h0,2'd3,1'b0,1'b0},
        '{1'b1,2'd1,1'b0,12'h228,4'h0,1'b1,1'b0,1'b1,4'd4,2'd1, 1'b1,5'd2, 12'h228,4'h0,2'd1,1'b0,1'b0},
        '{1'b1,2'd3,1'b0,12'h228,4'h0,1'b1,1'b1,1'b1,4'd0,2'd0, 1'b1,5'd2, 12'h228,4'h0,2'd3,1'b0,1'b0},
        '{1'b1,2'd3,1'b0,12'h068,4'h0,1'b1,1'b1,1'b1,4'd0,2'd0, 1'b0,5'd0, 12'h00A,4'h0,2'd3,1'b0,1'b0},
        '{1'b1,2'd3,1'b0,12'h228,4'h0,1'b1,1'b0,1'b1,4'd0,2'd1, 1'b1,5'd0, 12'h228,4'h0,2'd3,1'b0,1'b0},
        '{1'b0,2'd1,1'b0,12'h014,4'h5,1'b1,1'b1,1'b1,4'd4,2'd0, 1'b0,5'd0, 12'h005,4'h4,2'd1,1'b1,1'b1},
        '{1'b0,2'd1,1'b0,12'h001,4'h0,1'b1,1'b1,1'b1,4'd0,2'd0, 1'b0,5'd0, 12'h004,4'h0,2'd0,1'b0,1'b0},
        '{1'b0,2'd0,1'b0,12'h014,4'h0,1'b1,1'b1,1'b1,4'd4,2'd0, 1'b1,5'd2, 12'h014,4'h0,2'd0,1'b0,1'b0},
        '{1'b0,2'd1,1'b0,12'h114,4'h0,1'b1,1'b1,1'b1,4'd4,2'd0, 1'b1,5'd2, 12'h114,4'h0,2'd1,1'b0,1'b0},
        '{1'b0,2'd3,1'b0,12'h114,4'h0,1'b1,1'b1,1'b1,4'd4,2'd0, 1'b0,5'd0, 12'h105,4'h0,2'd1,1'b0,1'b0},
        '{1'b0,2'd1,1'b1,12'h014,4'h2,1'b1,1'b1,1'b1,4'd4,2'd0, 1'b1,5'd22,12'h014,4'h2,2'd1,1'b1,1'b0},
        '{1'b0,2'd1,1'b1,12'h014,4'h1,1'b1,1'b1,1'b1,4'd4,2'd0, 1'b0,5'd0, 12'h005,4'h1,2'd1,1'b1,1'b0},
        '{1'b0,2'd1,1'b1,12'h114,4'h2,1'b1,1'b1,1'b1,4'd4,2'd0, 1'b1,5'd2, 12'h114,4'h2,2'd1,1'b1,1'b0},
        '{1'b0,2'd1,1'b0,12'h114,4'h0,1'b1,1'b0,1'b1,4'd4,2'd3, 1'b1,5'd0, 12'h114,4'h0,2'd1,1'b0,1'b0},
        '{1'b0,2'd1,1'b0,12'h014,4'h1,1'b0,1'b1,1'b1,4'd4,2'd0, 1'b0,5'd0, 12'h005,4'h1,2'd1,1'b0,1'b0},
        '{1'b1,2'd3,1'b0,12'h228,4'h0,1'b1,1'b1,1'b0,4'd0,2'd0, 1'b0,5'd0, 12'h20A,4'h0,2'd1,1'b0,1'b0}
    };
    // requirement each vector targets
    localparam string VREQ [NV] = '{
        "R9", "R9", "R9", "R2", "R3", "R7", "R6", "R6", "R7", "R10",
        "R11", "R2", "R4", "R4", "R5", "R11", "R7", "R7", "R11", "R6"
    };

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic drive_idle();
        req_valid = 1'b0; req_is_mret = 1'b0; cur_priv = 2'd3; cur_virt = 1'b0;
        mstat_in = '0; hstat_in = '0; mepc_in = MEPC_BASE; sepc_in = SEPC_BASE;
        cfg_has_h = 1'b1; cfg_has_c = 1'b1; cfg_has_pmp = 1'b1; pmp_rules = 4'd4;
    endtask

    // watchdog: a hung run is counted as a failed check
    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        n_cmp++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        drive_idle();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", "done", 32'(done), 0);
        check("R1", "refused", 32'(refused), 0);
        check("R1", "priv_out", 32'(priv_out), 3);
        check("R1", "virt_out", 32'(virt_out), 0);
        check("R1", "pc_out", pc_out, 0);
        check("R12", "swap_regs", 32'(swap_regs), 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            vec_t v;
            v = VECS[i];
            req_is_mret = v.mret; cur_priv = v.priv; cur_virt = v.virt;
            mstat_in = v.ms; hstat_in = v.hs;
            cfg_has_h = v.h; cfg_has_c = v.c; cfg_has_pmp = v.pmp; pmp_rules = v.rules;
            mepc_in = {MEPC_BASE[XLEN-1:2], v.pclo};
            sepc_in = {SEPC_BASE[XLEN-1:2], v.pclo};
            req_valid = 1'b1;
            @(negedge clk);
            req_valid = 1'b0;
            check("R1", "done", 32'(done), 1);
            check(VREQ[i], "refused", 32'(refused), 32'(v.e_ref));
            check(VREQ[i], "excp_code", 32'(excp_code), 32'(v.e_code));
            check(v.e_ref ? "R8" : VREQ[i], "mstat_out", 32'(mstat_out), 32'(v.e_ms));
            check(v.e_ref ? "R8" : VREQ[i], "hstat_out", 32'(hstat_out), 32'(v.e_hs));
            check(v.e_ref ? "R8" : VREQ[i], "priv_out", 32'(priv_out), 32'(v.e_priv));
            check(v.e_ref ? "R8" : VREQ[i], "virt_out", 32'(virt_out), 32'(v.e_virt));
            check("R12", "swap_regs", 32'(swap_regs), 32'(v.e_swap));
            check("R13", "pc_out", pc_out, v.mret ? mepc_in : sepc_in);
        end

        // R1 and R12: idle cycle drops the pulses, result held
        @(negedge clk);
        check("R1", "done idle", 32'(done), 0);
        check("R12", "swap idle", 32'(swap_regs), 0);
        check("R1", "priv held", 32'(priv_out), 1);

        // R12: swap pulse lasts one cycle after a restoring machine return
        req_is_mret = 1'b1; cur_priv = 2'd3; cur_virt = 1'b0; mstat_in = 12'h0A2;
        cfg_has_h = 1'b1; cfg_has_c = 1'b1; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check("R12", "swap pulse", 32'(swap_regs), 1);
        @(negedge clk);
        check("R12", "swap one cycle", 32'(swap_regs), 0);
        check("R1", "done one cycle", 32'(done), 0);

        // R1: synchronous reset after activity restores reset values
        rst_n = 1'b0;
        @(negedge clk);
        check("R1", "priv after reset", 32'(priv_out), 3);
        check("R1", "virt after reset", 32'(virt_out), 0);
        check("R1", "pc after reset", pc_out, 0);
        rst_n = 1'b1;
        @(negedge clk);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule